// File: doc/BRIEF.md
# Bus-Master IDE DMA Register Window

This block is the host-visible register window of a two-channel bus-master IDE DMA controller. A host reaches it through a simple synchronous register bus carrying a read strobe, a write strobe, a byte address, an access size and 32-bit write data. Each channel has an 8-byte slice of a 16-byte window holding a command byte, a status byte and a 32-bit descriptor-table pointer. The block enforces the access rules of that window and drives start, direction and pointer signals toward a DMA engine that lives outside it.

The DMA engine and the drive report back through per-channel event inputs: a one-cycle transfer-done pulse, a one-cycle error pulse and a level-sensitive drive interrupt line. These set or clear status bits in hardware, while software owns other status bits and clears the sticky event bits by writing ones. Read data comes back right-justified on `host_rdata` one clock after the read strobe, qualified by `host_rvalid`.

Top module: `bmdma_regwin`

## Requirements
- R1: After reset, every command, status and pointer register of both channels reads zero, and `dma_start`, `dma_to_mem` and `dma_desc_addr` are zero.
- R2: Channel c owns window offsets 8c to 8c+7; within a channel, local offset 0 is command, local offset 2 is status and local offsets 4 to 7 hold the pointer (offset 4 is its least significant byte). Read data appears right-justified on `host_rdata` with `host_rvalid` high exactly one cycle after `host_rd`.
- R3: A byte read at local offset 1 or 3 returns 0xFF; a write there changes no register.
- R4: Access size is encoded 0 = byte, 1 = halfword, 2 or 3 = word. At local offsets 0 to 3 only byte accesses take effect: a halfword read returns 0x0000FFFF, a word read returns 0xFFFFFFFF, and a wider write changes nothing.
- R5: Command bit 0 is start and bit 3 is direction (1 = transfer into memory); the other command bits read 0. `dma_start[c]` and `dma_to_mem[c]` follow these bits.
- R6: Status bit 0 (active) is set by a command write with bit 0 = 1 and cleared by a command write with bit 0 = 0 or by a `dma_done` pulse; a command write in the same cycle as `dma_done` takes priority. A status write never changes bit 0.
- R7: A status write loads bits 6 and 5 from the data; status bits 7, 4 and 3 always read 0.
- R8: A status write clears bit 2 and bit 1 wherever the written data has a 1 and leaves them unchanged where it has a 0.
- R9: A rising edge on `drive_irq[c]` sets status bit 2 and a `dma_err[c]` pulse sets status bit 1; a hardware set in the same cycle as a software clear leaves the bit set. A line held high sets bit 2 only once.
- R10: The pointer accepts byte, halfword and word writes at any local offset 4 to 7; bytes that would fall beyond local offset 7 are dropped, reads return the addressed bytes masked to the access width, and bits 1:0 always read 0. `dma_desc_addr` carries the pointer.
- R11: An access to one channel never changes the other channel's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_addr | input | 4 | Byte offset in the window |
| host_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | 32 | Write data, right-justified |
| host_rdata | output | 32 | Read data, right-justified |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| drive_irq | input | 2 | Per-channel drive interrupt level |
| dma_err | input | 2 | Per-channel engine error pulse |
| dma_done | input | 2 | Per-channel transfer-done pulse |
| dma_start | output | 2 | Per-channel start bit |
| dma_to_mem | output | 2 | Per-channel direction bit, 1 = into memory |
| dma_desc_addr | output | 64 | Per-channel pointer, channel c at bits 32c+31:32c |

## Verification
The assertions take for granted that the host never raises read and write together, that every address lies inside the 16-byte window, and that the engine inputs are synchronous to `clk`, with `dma_err` and `dma_done` driven as single-cycle pulses. The stimulus issues one access at a time on falling edges, holds event pulses for exactly one cycle, and keeps `drive_irq` as a level that is raised and lowered with at least one idle cycle between changes. The cases where hardware and software touch the same status bit in one cycle are driven on purpose to exercise the priority rules.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // Number of bytes covered by a size code.
  function automatic int size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Mask of the valid read lanes for a size code.
  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Status byte after a host write: software bits load, sticky bits clear on one.
  function automatic logic [7:0] status_sw_write(input logic [7:0] cur, input logic [7:0] wd);
    logic [7:0] r;
    r      = 8'h00;
    r[6:5] = wd[6:5];
    r[2]   = cur[2] & ~wd[2];
    r[1]   = cur[1] & ~wd[1];
    r[0]   = cur[0];
    return r;
  endfunction

  // Merge written lanes into the pointer, dropping lanes past its top byte.
  function automatic logic [31:0] ptr_merge(input logic [31:0] cur, input logic [1:0] off,
                                            input logic [1:0] sz, input logic [31:0] wd);
    logic [31:0] r;
    int n;
    r = cur;
    n = size_bytes(sz);
    for (int j = 0; j < 4; j++) begin
      if (j < n && (int'(off) + j) < 4)
        r[8*(int'(off)+j) +: 8] = wd[8*j +: 8];
    end
    r[1:0] = 2'b00;
    return r;
  endfunction

  // Right-justified pointer bytes starting at an offset, masked to the width.
  function automatic logic [31:0] ptr_read(input logic [31:0] cur, input logic [1:0] off,
                                           input logic [1:0] sz);
    return (cur >> (8 * int'(off))) & size_mask(sz);
  endfunction

endpackage

// File: rtl/bmdma_edge.sv
module bmdma_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  loc_off,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  input  logic        irq_rise,
  input  logic        err_ev,
  input  logic        done_ev,
  output logic [7:0]  cmd_q,
  output logic [7:0]  stat_q,
  output logic [31:0] ptr_q
);
  logic cmd_wr, stat_wr, ptr_wr;
  logic [7:0] stat_n;

  assign cmd_wr  = wr && (size == SZ_BYTE) && (loc_off == 3'd0);
  assign stat_wr = wr && (size == SZ_BYTE) && (loc_off == 3'd2);
  assign ptr_wr  = wr && loc_off[2];

  always_comb begin
    stat_n = stat_wr ? status_sw_write(stat_q, wdata[7:0]) : stat_q;
    if (irq_rise) stat_n[2] = 1'b1;
    if (err_ev)   stat_n[1] = 1'b1;
    if (cmd_wr)       stat_n[0] = wdata[0];
    else if (done_ev) stat_n[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 8'h00;
      stat_q <= 8'h00;
      ptr_q  <= 32'h0;
    end else begin
      if (cmd_wr) cmd_q <= {4'h0, wdata[3], 2'b00, wdata[0]};
      stat_q <= stat_n;
      if (ptr_wr) ptr_q <= ptr_merge(ptr_q, loc_off[1:0], size, wdata);
    end
  end
endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
  import bmdma_pkg::*;
#(
  parameter int NCH = 2,
  localparam int AW = $clog2(NCH) + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  input  logic [1:0]       host_size,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  output logic             host_rvalid,
  input  logic [NCH-1:0]   drive_irq,
  input  logic [NCH-1:0]   dma_err,
  input  logic [NCH-1:0]   dma_done,
  output logic [NCH-1:0]   dma_start,
  output logic [NCH-1:0]   dma_to_mem,
  output logic [NCH*32-1:0] dma_desc_addr
);
  logic [AW-1:0] ch_idx;
  logic [2:0]    loc_off;
  logic [7:0]    cmd_a  [NCH];
  logic [7:0]    stat_a [NCH];
  logic [31:0]   ptr_a  [NCH];
  logic [NCH-1:0]   irq_rise;
  logic [NCH*8-1:0] stat_flat;
  logic [31:0]   rd_val;

  assign ch_idx  = host_addr >> 3;
  assign loc_off = host_addr[2:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = host_wr && (ch_idx == AW'(c));

    bmdma_edge u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (drive_irq[c]),
      .rise (irq_rise[c])
    );

    bmdma_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (hit),
      .loc_off (loc_off),
      .size    (host_size),
      .wdata   (host_wdata),
      .irq_rise(irq_rise[c]),
      .err_ev  (dma_err[c]),
      .done_ev (dma_done[c]),
      .cmd_q   (cmd_a[c]),
      .stat_q  (stat_a[c]),
      .ptr_q   (ptr_a[c])
    );

    assign dma_start[c]            = cmd_a[c][0];
    assign dma_to_mem[c]           = cmd_a[c][3];
    assign dma_desc_addr[32*c +: 32] = ptr_a[c];
    assign stat_flat[8*c +: 8]     = stat_a[c];
  end

  always_comb begin
    rd_val = 32'h0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_idx == AW'(c)) begin
        if (loc_off[2])
          rd_val = ptr_read(ptr_a[c], loc_off[1:0], host_size);
        else if (host_size != SZ_BYTE)
          rd_val = size_mask(host_size);
        else begin
          case (loc_off[1:0])
            2'd0:    rd_val = {24'h0, cmd_a[c]};
            2'd2:    rd_val = {24'h0, stat_a[c]};
            default: rd_val = 32'h0000_00FF;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= 32'h0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/bmdma_regwin_chk.sv
module bmdma_regwin_chk #(
  parameter int NCH = 2,
  parameter int AW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_rd,
  input logic             host_wr,
  input logic [AW-1:0]    host_addr,
  input logic [1:0]       host_size,
  input logic [31:0]      host_rdata,
  input logic             host_rvalid,
  input logic [NCH-1:0]   irq_rise,
  input logic [NCH-1:0]   dma_err,
  input logic [NCH-1:0]   dma_done,
  input logic [NCH*8-1:0] stat_flat,
  input logic [NCH*32-1:0] dma_desc_addr
);
  assert_rvalid_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  assert_wide_read_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_size != 2'd0 && !host_addr[2]) |=>
      host_rdata == (($past(host_size) == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic cmd_hit, stat_hit;
    assign cmd_hit  = host_wr && host_size == 2'd0 && host_addr == AW'(8*c);
    assign stat_hit = host_wr && host_size == 2'd0 && host_addr == AW'(8*c + 2);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_flat[8*c+7] == 1'b0 && stat_flat[8*c+4] == 1'b0 && stat_flat[8*c+3] == 1'b0);

    assert_ptr_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dma_desc_addr[32*c +: 2] == 2'b00);

    assert_irq_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rise[c] |=> stat_flat[8*c+2]);

    assert_err_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_err[c] |=> stat_flat[8*c+1]);

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done[c] && !cmd_hit) |=> !stat_flat[8*c]);

    assert_active_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_hit && !dma_done[c]) |=> $stable(stat_flat[8*c]));
  end
endmodule

bind bmdma_regwin bmdma_regwin_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_rd      (host_rd),
  .host_wr      (host_wr),
  .host_addr    (host_addr),
  .host_size    (host_size),
  .host_rdata   (host_rdata),
  .host_rvalid  (host_rvalid),
  .irq_rise     (irq_rise),
  .dma_err      (dma_err),
  .dma_done     (dma_done),
  .stat_flat    (stat_flat),
  .dma_desc_addr(dma_desc_addr)
);

// File: tb/tb_bmdma_regwin.sv
`timescale 1ns/100ps
module tb_bmdma_regwin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [1:0]  drive_irq = '0, dma_err = '0, dma_done = '0;
  logic [1:0]  dma_start, dma_to_mem;
  logic [63:0] dma_desc_addr;

  int n_run = 0, n_fail = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  bmdma_regwin dut (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .drive_irq(drive_irq), .dma_err(dma_err), .dma_done(dma_done),
    .dma_start(dma_start), .dma_to_mem(dma_to_mem), .dma_desc_addr(dma_desc_addr)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data when the design presents it.
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (sb_q.size() == 0) chk(1, 0, "R2 unexpected rvalid");
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(host_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [1:0] s, input logic [31:0] e, input string t);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a; host_size = s;
    sb_q.push_back('{e, t});
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wr_ev(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d,
                       input logic [1:0] err, input logic [1:0] done);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_size = s; host_wdata = d;
    dma_err = err; dma_done = done;
    @(negedge clk);
    host_wr = 1'b0; dma_err = '0; dma_done = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    wr_ev(a, s, d, 2'b00, 2'b00);
  endtask

  task automatic pulse(input logic [1:0] err, input logic [1:0] done);
    @(negedge clk);
    dma_err = err; dma_done = done;
    @(negedge clk);
    dma_err = '0; dma_done = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    chk({dma_start, dma_to_mem}, 4'h0, "R1 outputs");
    chk(dma_desc_addr, 64'h0, "R1 pointers");
    rd(4'h0, 2'd0, 32'h00, "R1 cmd0");
    rd(4'h2, 2'd0, 32'h00, "R1 stat0");
    rd(4'h4, 2'd2, 32'h0,  "R1 ptr0");
    rd(4'h8, 2'd0, 32'h00, "R1 cmd1");
    rd(4'hA, 2'd0, 32'h00, "R1 stat1");
    rd(4'hC, 2'd2, 32'h0,  "R1 ptr1");

    // R5 / R6: start with direction
    wr(4'h0, 2'd0, 32'h09);
    chk(dma_start, 2'b01, "R5 start out");
    chk(dma_to_mem, 2'b01, "R5 dir out");
    rd(4'h0, 2'd0, 32'h09, "R5 cmd read");
    rd(4'h2, 2'd0, 32'h01, "R6 active set");
    rd(4'h8, 2'd0, 32'h00, "R11 cmd1 untouched");
    wr(4'h0, 2'd0, 32'hFF);
    rd(4'h0, 2'd0, 32'h09, "R5 unused cmd bits");

    // R7 / R6: status write semantics
    wr(4'h2, 2'd0, 32'hFF);
    rd(4'h2, 2'd0, 32'h61, "R7 sw bits load");
    wr(4'h2, 2'd0, 32'h00);
    rd(4'h2, 2'd0, 32'h01, "R6 active kept on status write");

    // R9 / R8: hardware sets and W1C
    pulse(2'b01, 2'b00);
    rd(4'h2, 2'd0, 32'h03, "R9 err sets bit1");
    @(negedge clk); drive_irq = 2'b01;
    @(negedge clk);
    rd(4'h2, 2'd0, 32'h07, "R9 irq rise sets bit2");
    wr(4'h2, 2'd0, 32'h04);
    rd(4'h2, 2'd0, 32'h03, "R8 clear bit2");
    repeat (3) @(negedge clk);
    rd(4'h2, 2'd0, 32'h03, "R9 held irq no reset");
    wr(4'h2, 2'd0, 32'h02);
    rd(4'h2, 2'd0, 32'h01, "R8 clear bit1");
    @(negedge clk); drive_irq = 2'b00;
    wr_ev(4'h2, 2'd0, 32'h02, 2'b01, 2'b00);
    rd(4'h2, 2'd0, 32'h03, "R9 hw set wins over clear");

    // R6: done and command priority
    pulse(2'b00, 2'b01);
    rd(4'h2, 2'd0, 32'h02, "R6 done clears active");
    wr_ev(4'h0, 2'd0, 32'h01, 2'b00, 2'b01);
    rd(4'h2, 2'd0, 32'h03, "R6 start beats done");
    chk({dma_start, dma_to_mem}, 4'b0100, "R5 outputs after rewrite");
    wr(4'h0, 2'd0, 32'h00);
    rd(4'h2, 2'd0, 32'h02, "R6 stop clears active");
    chk(dma_start, 2'b00, "R5 stop output");

    // R3: unused byte offsets
    rd(4'h1, 2'd0, 32'hFF, "R3 read off1");
    rd(4'hB, 2'd0, 32'hFF, "R3 read off3 ch1");
    wr(4'h1, 2'd0, 32'h55);
    wr(4'h3, 2'd0, 32'h55);
    rd(4'h0, 2'd0, 32'h00, "R3 cmd untouched");
    rd(4'h2, 2'd0, 32'h02, "R3 status untouched");

    // R4: wide accesses to command/status
    rd(4'h0, 2'd1, 32'h0000FFFF, "R4 half read");
    rd(4'h0, 2'd2, 32'hFFFFFFFF, "R4 word read");
    rd(4'hA, 2'd1, 32'h0000FFFF, "R4 half read ch1");
    rd(4'h8, 2'd3, 32'hFFFFFFFF, "R4 size3 read");
    wr(4'h8, 2'd2, 32'hFFFFFFFF);
    chk(dma_start, 2'b00, "R4 wide write ignored");
    rd(4'h8, 2'd0, 32'h00, "R4 cmd1 unchanged");
    rd(4'hA, 2'd0, 32'h00, "R4 stat1 unchanged");

    // R10: pointer writes
    wr(4'h4, 2'd2, 32'h12345677);
    rd(4'h4, 2'd2, 32'h12345674, "R10 word write aligned");
    chk(dma_desc_addr[31:0], 32'h12345674, "R10 pointer out");
    wr(4'h6, 2'd0, 32'h000000AB);
    rd(4'h4, 2'd2, 32'h12AB5674, "R10 byte write");
    wr(4'hC, 2'd1, 32'h0000CDEF);
    rd(4'hC, 2'd2, 32'h0000CDEC, "R10 half write ch1");
    wr(4'hD, 2'd2, 32'hAABBCCDD);
    rd(4'hC, 2'd2, 32'hBBCCDDEC, "R10 lanes past top dropped");
    rd(4'hD, 2'd0, 32'h000000DD, "R10 byte read");
    rd(4'hE, 2'd1, 32'h0000BBCC, "R10 half read");
    chk(dma_desc_addr, 64'hBBCCDDEC_12AB5674, "R11 pointers independent");

    // R11: channel 1 status independent
    wr(4'hA, 2'd0, 32'h20);
    rd(4'hA, 2'd0, 32'h20, "R11 stat1 write");
    rd(4'h2, 2'd0, 32'h02, "R11 stat0 unaffected");
    pulse(2'b10, 2'b00);
    rd(4'hA, 2'd0, 32'h22, "R11 err ch1");
    rd(4'h2, 2'd0, 32'h02, "R11 ch0 after ch1 err");

    repeat (3) @(negedge clk);
    chk(sb_q.size(), 0, "R2 all reads answered");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule